// File: doc/BRIEF.md
# SDRAM Four-Bank Command Scheduler

This block sits between a simple host port and a four-bank synchronous DRAM. The host presents one access at a time (bank, row, column, read or write, and an auto-precharge choice) and holds it until the block acknowledges it. The block keeps a record of the open row in every bank. It decides whether the access can go straight to a column command, must first close a different row, or must first open the row. It then drives the chip-select, row-strobe, column-strobe, write-enable, bank and address lines. Every spacing rule is counted in whole clock cycles.

After reset the block brings the device up on its own: it closes all banks, refreshes twice, loads the mode register, and only then serves the host. While running, a free-running interval timer asks for a refresh. The block lets any access already under way finish. It then closes every bank and issues an auto refresh, which keeps the row-active limit and the refresh budget both met. Data capture and pad timing are handled elsewhere.

Top module: `sdram_bank_ctrl`

## Requirements
- R1: The command lines {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} carry these codes: activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode load 0000, no-op 0111. Deselect has sd_cs_n high. The burst-stop code 0110 is never issued.
- R2: After reset the first four commands are: precharge with sd_addr[10]=1, auto refresh, auto refresh, and mode load with sd_addr equal to MODE_WORD (default 13'h030) and sd_ba=0. No request is acknowledged before the mode load.
- R3: A request to the row that is already open in its bank produces only its read or write command, with no activate and no precharge. Banks keep their open rows independently.
- R4: A request to a bank whose open row differs produces a precharge of that bank (sd_addr[10]=0), then an activate of the new row, then the read or write.
- R5: A request to a closed bank produces an activate (sd_addr = row) and then the read or write.
- R6: Read and write commands carry the column on sd_addr[COL_W-1:0] and the request's auto-precharge flag on sd_addr[10], with all other address bits zero. A bank closed by auto precharge is reopened by a plain activate, with no precharge first.
- R7: A read or write follows the activate of its bank by at least T_RCD (3) cycles.
- R8: In the same bank, activate-to-precharge spacing is at least T_RAS (6) cycles, activate-to-activate at least T_RC (9), and precharge-to-activate at least T_RP (3).
- R9: Activates to any two banks are at least T_RRD (2) cycles apart. A precharge follows a write to its bank by at least T_WR (2) cycles.
- R10: The block requests a refresh every REF_INTERVAL (2083) cycles from reset. It serves the request with an all-bank precharge followed by an auto refresh, and every open row is then closed. No command other than no-op follows an auto refresh within T_RFC (10) cycles or a mode load within T_RSC (2) cycles.
- R11: req_ack is high for exactly one cycle, the same cycle in which the read or write command for that request is on the bus.
- R12: During reset the bus shows deselect and req_ack is low. With no work, the bus shows no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until req_ack |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | $clog2(BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_autopre | input | 1 | Close the row after this access |
| req_ack | output | 1 | Column command issued for the request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | $clog2(BANKS) | Bank address |
| sd_addr | output | ADDR_W | Row, column or mode word; bit 10 selects auto or all-bank precharge |

## Verification
The bench drives several request patterns: an access to a closed bank, a repeat to the open row, a different row in the same bank, an auto-precharged write followed by a return to that row, and interleaved accesses across other banks. Comparing the resulting command lists separates the hit, miss and closed-bank paths. It also shows whether the per-bank record survives traffic to other banks. A bus monitor checks the spacing of every command pair against the cycle rules. A long idle stretch confirms that the refresh sequence arrives on time and leaves every row closed.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS   = 4'b0000,
      CMD_REFA  = 4'b0001,
      CMD_PRE   = 4'b0010,
      CMD_ACT   = 4'b0011,
      CMD_WR    = 4'b0100,
      CMD_RD    = 4'b0101,
      CMD_NOP   = 4'b0111,
      CMD_DESEL = 4'b1111
   } sdc_cmd_e;

   typedef enum logic [2:0] {
      ST_INI_PRE,
      ST_INI_REF1,
      ST_INI_REF2,
      ST_INI_MRS,
      ST_RUN,
      ST_REF_PRE,
      ST_REF
   } sdc_state_e;

   // address bit that selects auto precharge / all-bank precharge
   localparam int AP_BIT = 10;

endpackage

// File: rtl/sdc_bank.sv
module sdc_bank #(
   parameter int ROW_W = 13,
   parameter int CNT_W = 6,
   parameter int T_RCD = 3,
   parameter int T_RP  = 3,
   parameter int T_RAS = 6,
   parameter int T_RC  = 9,
   parameter int T_WR  = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             pre_i,
   input  logic             rw_i,
   input  logic             wr_i,
   input  logic             ap_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             act_ok_o,
   output logic             pre_ok_o,
   output logic             rw_ok_o
);

   // a counter loaded with N-1 permits the command N cycles later
   localparam logic [CNT_W-1:0] RC_L  = CNT_W'(T_RC - 1);
   localparam logic [CNT_W-1:0] RAS_L = CNT_W'(T_RAS - 1);
   localparam logic [CNT_W-1:0] RCD_L = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] RP_L  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] WR_L  = CNT_W'(T_WR - 1);
   localparam logic [CNT_W-1:0] RPF_L = CNT_W'(T_RP);

   logic [CNT_W-1:0] act_c, pre_c, rcd_c;
   logic [CNT_W-1:0] act_n, pre_n, rcd_n;

   always_comb begin
      act_n = (act_c != '0) ? act_c - CNT_W'(1) : '0;
      pre_n = (pre_c != '0) ? pre_c - CNT_W'(1) : '0;
      rcd_n = (rcd_c != '0) ? rcd_c - CNT_W'(1) : '0;
      if (act_i) begin
         act_n = RC_L;
         pre_n = RAS_L;
         rcd_n = RCD_L;
      end
      if (pre_i && act_n < RP_L) act_n = RP_L;
      if (wr_i && pre_n < WR_L) pre_n = WR_L;
      // internal precharge starts once the precharge window opens
      if (rw_i && ap_i && act_n < pre_n + RPF_L) act_n = pre_n + RPF_L;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_c  <= '0;
         pre_c  <= '0;
         rcd_c  <= '0;
         open_o <= 1'b0;
         row_o  <= '0;
      end else begin
         act_c <= act_n;
         pre_c <= pre_n;
         rcd_c <= rcd_n;
         if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
         end else if (pre_i || (rw_i && ap_i)) begin
            open_o <= 1'b0;
         end
      end
   end

   assign act_ok_o = (act_c == '0);
   assign pre_ok_o = (pre_c == '0);
   assign rw_ok_o  = (rcd_c == '0);

endmodule

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
   parameter int REF_INTERVAL = 2083
)(
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   output logic pend_o
);

   localparam int TW = $clog2(REF_INTERVAL + 1);
   localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         pend_o <= 1'b0;
      end else begin
         if (cnt == LAST) cnt <= '0;
         else             cnt <= cnt + TW'(1);
         if (cnt == LAST)  pend_o <= 1'b1;
         else if (done_i)  pend_o <= 1'b0;
      end
   end

endmodule

// File: rtl/sdram_bank_ctrl.sv
module sdram_bank_ctrl
   import sdc_pkg::*;
#(
   parameter int BANKS        = 4,
   parameter int ADDR_W       = 13,
   parameter int ROW_W        = 13,
   parameter int COL_W        = 10,
   parameter int T_RCD        = 3,
   parameter int T_RP         = 3,
   parameter int T_RAS        = 6,
   parameter int T_RC         = 9,
   parameter int T_RFC        = 10,
   parameter int T_WR         = 2,
   parameter int T_RRD        = 2,
   parameter int T_RSC        = 2,
   parameter int REF_INTERVAL = 2083,
   parameter int RAS_MAX      = 13333,
   parameter logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(12'h030)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [$clog2(BANKS)-1:0] req_bank,
   input  logic [ROW_W-1:0]         req_row,
   input  logic [COL_W-1:0]         req_col,
   input  logic                     req_autopre,
   output logic                     req_ack,
   output logic                     sd_cs_n,
   output logic                     sd_ras_n,
   output logic                     sd_cas_n,
   output logic                     sd_we_n,
   output logic [$clog2(BANKS)-1:0] sd_ba,
   output logic [ADDR_W-1:0]        sd_addr
);

   localparam int BA_W  = $clog2(BANKS);
   localparam int CNT_W = $clog2(T_RC + T_RAS + T_RP + T_WR + 1) + 1;
   localparam int GCW   = $clog2(T_RFC + T_RSC + T_RRD + 1) + 1;

   // elaboration-time parameter checks
   if (COL_W > AP_BIT) begin : g_err_col
      $error("column field overlaps the auto precharge bit");
   end
   if (ADDR_W <= AP_BIT || ROW_W > ADDR_W) begin : g_err_addr
      $error("address bus too narrow for row or precharge bit");
   end
   if ((1 << BA_W) != BANKS) begin : g_err_banks
      $error("bank count must be a power of two");
   end
   if (REF_INTERVAL >= RAS_MAX) begin : g_err_ref
      $error("refresh interval must close rows before the row-active limit");
   end

   sdc_state_e st, st_n;
   sdc_cmd_e   cmd_q, nxt;
   logic [BA_W-1:0]   ba_q, nba;
   logic [ADDR_W-1:0] addr_q, naddr;
   logic ack_q, nack, mid;
   logic [GCW-1:0] gblk, rrd;
   logic ref_pend;

   logic [BANKS-1:0] b_open, b_act_ok, b_pre_ok, b_rw_ok;
   logic [ROW_W-1:0] b_row [BANKS];

   logic go_act, go_pre, go_rw, go_refa, go_mrs, pre_all, idle_g;

   assign go_act  = (nxt == CMD_ACT);
   assign go_pre  = (nxt == CMD_PRE);
   assign go_rw   = (nxt == CMD_RD) || (nxt == CMD_WR);
   assign go_refa = (nxt == CMD_REFA);
   assign go_mrs  = (nxt == CMD_MRS);
   assign pre_all = go_pre && naddr[AP_BIT];
   assign idle_g  = (gblk == '0);

   for (genvar g = 0; g < BANKS; g++) begin : g_bank
      logic sel;
      assign sel = (nba == BA_W'(g));
      sdc_bank #(
         .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP),
         .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .act_i    (go_act && sel),
         .pre_i    (go_pre && (sel || naddr[AP_BIT])),
         .rw_i     (go_rw && sel),
         .wr_i     ((nxt == CMD_WR) && sel),
         .ap_i     (naddr[AP_BIT]),
         .row_i    (req_row),
         .open_o   (b_open[g]),
         .row_o    (b_row[g]),
         .act_ok_o (b_act_ok[g]),
         .pre_ok_o (b_pre_ok[g]),
         .rw_ok_o  (b_rw_ok[g])
      );
   end

   sdc_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_i (go_refa && st == ST_REF),
      .pend_o (ref_pend)
   );

   always_comb begin
      st_n  = st;
      nxt   = CMD_NOP;
      nba   = '0;
      naddr = '0;
      nack  = 1'b0;
      unique case (st)
         ST_INI_PRE, ST_REF_PRE: begin
            if (idle_g && &b_pre_ok) begin
               nxt           = CMD_PRE;
               naddr[AP_BIT] = 1'b1;
               st_n          = (st == ST_INI_PRE) ? ST_INI_REF1 : ST_REF;
            end
         end
         ST_INI_REF1, ST_INI_REF2, ST_REF: begin
            if (idle_g && &b_act_ok) begin
               nxt  = CMD_REFA;
               st_n = (st == ST_INI_REF1) ? ST_INI_REF2 :
                      (st == ST_INI_REF2) ? ST_INI_MRS  : ST_RUN;
            end
         end
         ST_INI_MRS: begin
            if (idle_g && &b_act_ok) begin
               nxt   = CMD_MRS;
               naddr = MODE_WORD;
               st_n  = ST_RUN;
            end
         end
         default: begin
            if (ref_pend && !mid) begin
               st_n = ST_REF_PRE;
            end else if (req_valid && !ack_q) begin
               nba = req_bank;
               if (b_open[req_bank] && b_row[req_bank] == req_row) begin
                  if (b_rw_ok[req_bank] && idle_g) begin
                     nxt                = req_write ? CMD_WR : CMD_RD;
                     naddr[COL_W-1:0]   = req_col;
                     naddr[AP_BIT]      = req_autopre;
                     nack               = 1'b1;
                  end
               end else if (b_open[req_bank]) begin
                  if (b_pre_ok[req_bank] && idle_g) nxt = CMD_PRE;
               end else if (b_act_ok[req_bank] && rrd == '0 && idle_g) begin
                  nxt   = CMD_ACT;
                  naddr = ADDR_W'(req_row);
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_INI_PRE;
         cmd_q  <= CMD_DESEL;
         ba_q   <= '0;
         addr_q <= '0;
         ack_q  <= 1'b0;
         mid    <= 1'b0;
         gblk   <= '0;
         rrd    <= '0;
      end else begin
         st     <= st_n;
         cmd_q  <= nxt;
         ba_q   <= nba;
         addr_q <= naddr;
         ack_q  <= nack;
         if (go_rw)                                mid <= 1'b0;
         else if (go_act || (go_pre && !pre_all))  mid <= 1'b1;
         if (go_refa)          gblk <= GCW'(T_RFC - 1);
         else if (go_mrs)      gblk <= GCW'(T_RSC - 1);
         else if (gblk != '0)  gblk <= gblk - GCW'(1);
         if (go_act)           rrd <= GCW'(T_RRD - 1);
         else if (rrd != '0)   rrd <= rrd - GCW'(1);
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba   = ba_q;
   assign sd_addr = addr_q;
   assign req_ack = ack_q;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
   parameter int BANKS        = 4,
   parameter int BA_W         = 2,
   parameter int T_RCD        = 3,
   parameter int T_RP         = 3,
   parameter int T_RAS        = 6,
   parameter int T_RC         = 9,
   parameter int T_RFC        = 10,
   parameter int T_WR         = 2,
   parameter int T_RRD        = 2,
   parameter int T_RSC        = 2,
   parameter int REF_INTERVAL = 2083
)(
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic [BA_W-1:0] ba,
   input logic            ap_bit,
   input logic            req_ack
);

   localparam int SW = 8;
   localparam logic [SW-1:0] SMAX = '1;
   localparam int AW = $clog2(2 * REF_INTERVAL + 1);

   if (T_RC >= 255 || T_RFC >= 255) begin : g_err_sat
      $error("spacing counters too narrow");
   end

   logic [3:0] c;
   logic is_act, is_pre, is_rw, is_wr, is_refa, is_mrs, is_cmd;
   assign c       = {cs_n, ras_n, cas_n, we_n};
   assign is_act  = (c == 4'b0011);
   assign is_pre  = (c == 4'b0010);
   assign is_wr   = (c == 4'b0100);
   assign is_rw   = (c == 4'b0101) || is_wr;
   assign is_refa = (c == 4'b0001);
   assign is_mrs  = (c == 4'b0000);
   assign is_cmd  = !cs_n && (c != 4'b0111);

   logic [SW-1:0] s_any_act, s_refa, s_mrs;
   logic [AW-1:0] ref_age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_any_act <= SMAX;
         s_refa    <= SMAX;
         s_mrs     <= SMAX;
         ref_age   <= '0;
      end else begin
         s_any_act <= is_act  ? SW'(1) : (s_any_act == SMAX ? SMAX : s_any_act + SW'(1));
         s_refa    <= is_refa ? SW'(1) : (s_refa    == SMAX ? SMAX : s_refa    + SW'(1));
         s_mrs     <= is_mrs  ? SW'(1) : (s_mrs     == SMAX ? SMAX : s_mrs     + SW'(1));
         ref_age   <= is_refa ? '0 : ref_age + AW'(1);
      end
   end

   for (genvar g = 0; g < BANKS; g++) begin : g_bk
      logic hit, pre_hit;
      logic [SW-1:0] s_act, s_pre, s_wr;
      assign hit     = (ba == BA_W'(g));
      assign pre_hit = is_pre && (hit || ap_bit);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_act <= SMAX;
            s_pre <= SMAX;
            s_wr  <= SMAX;
         end else begin
            s_act <= (is_act && hit) ? SW'(1) : (s_act == SMAX ? SMAX : s_act + SW'(1));
            s_pre <= pre_hit         ? SW'(1) : (s_pre == SMAX ? SMAX : s_pre + SW'(1));
            s_wr  <= (is_wr && hit)  ? SW'(1) : (s_wr  == SMAX ? SMAX : s_wr  + SW'(1));
         end
      end

      a_r7_rcd: assert property (@(posedge clk) disable iff (!rst_n)
         (is_rw && hit) |-> (s_act >= SW'(T_RCD)));
      a_r8_ras: assert property (@(posedge clk) disable iff (!rst_n)
         pre_hit |-> (s_act >= SW'(T_RAS)));
      a_r8_rc: assert property (@(posedge clk) disable iff (!rst_n)
         (is_act && hit) |-> (s_act >= SW'(T_RC)));
      a_r8_rp: assert property (@(posedge clk) disable iff (!rst_n)
         (is_act && hit) |-> (s_pre >= SW'(T_RP)));
      a_r9_wr: assert property (@(posedge clk) disable iff (!rst_n)
         pre_hit |-> (s_wr >= SW'(T_WR)));
   end

   a_r1_no_burst_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> (c != 4'b0110));
   a_r9_rrd: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (s_any_act >= SW'(T_RRD)));
   a_r10_rfc: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmd |-> (s_refa >= SW'(T_RFC)));
   a_r10_rsc: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmd |-> (s_mrs >= SW'(T_RSC)));
   a_r10_ref_due: assert property (@(posedge clk) disable iff (!rst_n)
      ref_age < AW'(2 * REF_INTERVAL));
   a_r11_ack_on_rw: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> is_rw);
   a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

endmodule

bind sdram_bank_ctrl sdc_checker #(
   .BANKS(BANKS), .BA_W($clog2(BANKS)), .T_RCD(T_RCD), .T_RP(T_RP),
   .T_RAS(T_RAS), .T_RC(T_RC), .T_RFC(T_RFC), .T_WR(T_WR),
   .T_RRD(T_RRD), .T_RSC(T_RSC), .REF_INTERVAL(REF_INTERVAL)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (sd_cs_n),
   .ras_n   (sd_ras_n),
   .cas_n   (sd_cas_n),
   .we_n    (sd_we_n),
   .ba      (sd_ba),
   .ap_bit  (sd_addr[10]),
   .req_ack (req_ack)
);

// File: tb/sdram_bank_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_bank_ctrl_tb;

   localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RFC = 10;
   localparam int T_WR = 2, T_RRD = 2, T_RSC = 2, REF_INT = 2083;
   localparam int C_MRS = 0, C_REFA = 1, C_PRE = 2, C_ACT = 3, C_WR = 4, C_RD = 5;

   typedef struct {int c; int b; int a; int t;} ev_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
   logic [1:0] req_bank = '0;
   logic [12:0] req_row = '0;
   logic [9:0] req_col = '0;
   logic req_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0] sd_ba;
   logic [12:0] sd_addr;

   int nchk = 0, nerr = 0, cyc = 0;
   bit done = 1'b0;
   ev_t lg[$];
   int last_act[4], last_pre[4], last_wr[4];
   int last_any = -1000, last_refa = -1000, last_mrs = -1000;

   sdram_bank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_autopre(req_autopre), .req_ack(req_ack), .sd_cs_n(sd_cs_n),
      .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bus monitor: logs commands and checks spacing rules
   initial begin
      for (int i = 0; i < 4; i++) begin
         last_act[i] = -1000; last_pre[i] = -1000; last_wr[i] = -1000;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !sd_cs_n &&
          {sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) begin
         ev_t e;
         e.c = int'({sd_ras_n, sd_cas_n, sd_we_n});
         e.b = int'(sd_ba);
         e.a = int'(sd_addr);
         e.t = cyc;
         lg.push_back(e);
         chk(e.t - last_refa >= T_RFC, "R10 gap after refresh", e.t - last_refa, T_RFC);
         chk(e.t - last_mrs >= T_RSC, "R10 gap after mode load", e.t - last_mrs, T_RSC);
         chk(e.c != 6, "R1 burst stop issued", e.c, 7);
         case (e.c)
            C_ACT: begin
               chk(e.t - last_act[e.b] >= T_RC, "R8 tRC", e.t - last_act[e.b], T_RC);
               chk(e.t - last_pre[e.b] >= T_RP, "R8 tRP", e.t - last_pre[e.b], T_RP);
               chk(e.t - last_any >= T_RRD, "R9 tRRD", e.t - last_any, T_RRD);
               last_act[e.b] = e.t;
               last_any = e.t;
            end
            C_RD, C_WR: begin
               chk(e.t - last_act[e.b] >= T_RCD, "R7 tRCD", e.t - last_act[e.b], T_RCD);
               if (e.c == C_WR) last_wr[e.b] = e.t;
               if (((e.a >> 10) & 1) == 1) last_pre[e.b] = e.t;
            end
            C_PRE: begin
               for (int i = 0; i < 4; i++) begin
                  if (i == e.b || ((e.a >> 10) & 1) == 1) begin
                     chk(e.t - last_act[i] >= T_RAS, "R8 tRAS", e.t - last_act[i], T_RAS);
                     chk(e.t - last_wr[i] >= T_WR, "R9 tWR", e.t - last_wr[i], T_WR);
                     last_pre[i] = e.t;
                  end
               end
            end
            C_REFA: last_refa = e.t;
            C_MRS:  last_mrs = e.t;
            default: ;
         endcase
      end
   end

   task automatic exp_ev(input int i, input int c, input int b, input int a, input string tag);
      if (i >= lg.size()) begin
         chk(1'b0, {tag, " missing command"}, lg.size(), i + 1);
      end else begin
         chk(lg[i].c == c, {tag, " command code"}, lg[i].c, c);
         chk(lg[i].b == b, {tag, " bank"}, lg[i].b, b);
         chk(lg[i].a == a, {tag, " address"}, lg[i].a, a);
      end
   endtask

   task automatic do_req(input bit w, input int b, input int row, input int col,
                         input bit ap, output int t_ack);
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = w; req_bank = 2'(b);
      req_row = 13'(row); req_col = 10'(col); req_autopre = ap;
      t_ack = -1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (req_ack) begin t_ack = cyc; break; end
      end
      chk(t_ack >= 0, "R11 ack seen", t_ack, 0);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      chk(!req_ack, "R11 ack single cycle", int'(req_ack), 0);
   endtask

   task automatic t_init();
      repeat (3) @(negedge clk);
      chk(sd_cs_n, "R12 deselect in reset", int'(sd_cs_n), 1);
      chk(!req_ack, "R12 ack low in reset", int'(req_ack), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (40) @(negedge clk);
      chk(lg.size() == 4, "R2 init command count", lg.size(), 4);
      exp_ev(0, C_PRE, 0, 1024, "R2 init precharge all");
      exp_ev(1, C_REFA, 0, 0, "R2 first refresh");
      exp_ev(2, C_REFA, 0, 0, "R2 second refresh");
      exp_ev(3, C_MRS, 0, 'h030, "R2 mode load");
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R12 idle no-op",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
   endtask

   task automatic t_closed_bank();
      int n0 = lg.size(), ta;
      do_req(1'b0, 0, 5, 7, 1'b0, ta);
      chk(lg.size() - n0 == 2, "R5 closed bank two commands", lg.size() - n0, 2);
      exp_ev(n0, C_ACT, 0, 5, "R5 activate row");
      exp_ev(n0 + 1, C_RD, 0, 7, "R6 read column");
      if (lg.size() > n0 + 1) begin
         chk(lg[n0 + 1].t == ta, "R11 ack with read", ta, lg[n0 + 1].t);
         chk(lg[n0 + 1].t - lg[n0].t >= T_RCD, "R7 act to read",
             lg[n0 + 1].t - lg[n0].t, T_RCD);
      end
   endtask

   task automatic t_row_hit();
      int n0 = lg.size(), ta;
      do_req(1'b1, 0, 5, 9, 1'b0, ta);
      chk(lg.size() - n0 == 1, "R3 hit single command", lg.size() - n0, 1);
      exp_ev(n0, C_WR, 0, 9, "R3 write on open row");
   endtask

   task automatic t_row_miss();
      int n0 = lg.size(), ta;
      do_req(1'b0, 0, 6, 2, 1'b0, ta);
      chk(lg.size() - n0 == 3, "R4 miss three commands", lg.size() - n0, 3);
      exp_ev(n0, C_PRE, 0, 0, "R4 single bank precharge");
      exp_ev(n0 + 1, C_ACT, 0, 6, "R4 activate new row");
      exp_ev(n0 + 2, C_RD, 0, 2, "R4 read");
   endtask

   task automatic t_autopre();
      int n0 = lg.size(), ta;
      do_req(1'b1, 1, 3, 4, 1'b1, ta);
      exp_ev(n0, C_ACT, 1, 3, "R6 activate bank one");
      exp_ev(n0 + 1, C_WR, 1, 1024 + 4, "R6 write with auto precharge");
      n0 = lg.size();
      do_req(1'b0, 1, 3, 5, 1'b0, ta);
      chk(lg.size() - n0 == 2, "R6 reopen count", lg.size() - n0, 2);
      exp_ev(n0, C_ACT, 1, 3, "R6 reopen without precharge");
      exp_ev(n0 + 1, C_RD, 1, 5, "R6 read after reopen");
   endtask

   task automatic t_multi_bank();
      int n0, ta;
      do_req(1'b0, 2, 1, 0, 1'b0, ta);
      do_req(1'b1, 3, 2, 8, 1'b0, ta);
      n0 = lg.size();
      do_req(1'b0, 0, 6, 1, 1'b0, ta);
      chk(lg.size() - n0 == 1, "R3 bank zero row kept", lg.size() - n0, 1);
      exp_ev(n0, C_RD, 0, 1, "R3 hit after other banks");
   endtask

   task automatic t_refresh();
      int k = -1, n0, ta;
      for (int i = 0; i < 3000 && k < 0; i++) begin
         @(negedge clk);
         for (int j = 4; j < lg.size(); j++) if (lg[j].c == C_REFA) k = j;
      end
      chk(k > 0, "R10 refresh issued", k, 1);
      if (k > 0) begin
         exp_ev(k - 1, C_PRE, 0, 1024, "R10 precharge all before refresh");
         chk(lg[k].t >= REF_INT && lg[k].t <= REF_INT + 40, "R10 refresh time",
             lg[k].t, REF_INT);
      end
      repeat (20) @(negedge clk);
      n0 = lg.size();
      do_req(1'b0, 0, 6, 3, 1'b0, ta);
      exp_ev(n0, C_ACT, 0, 6, "R10 rows closed by refresh");
   endtask

   initial begin
      t_init();
      t_closed_bank();
      t_row_hit();
      t_row_miss();
      t_autopre();
      t_multi_bank();
      t_refresh();
      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule